// File: doc/BRIEF.md
# Common Interrupt Distribution Unit

This block takes a set of external common interrupt inputs and steers each one to the interrupt lines of a group of cores. Every common interrupt has its own small state: a destination core mask, a packed mode word (distribution style and trigger type), a mask bit, a pending latch for edge inputs and an in-service flag that stays set until the interrupt is acknowledged. A delivered interrupt is held on exactly one core's line until software acknowledges it.

Software uses a single command port. A command carries an opcode, an interrupt index and a data word. Read commands load a readback register one cycle later, so software can read the mode word, change a field and write it back. An interrupt can go to one fixed core, or it can rotate among all cores in its destination mask, one delivery after another. Nothing is forwarded until the unit is globally enabled. On each core, common interrupt i appears on core-side line FIRST_LINE + i (24 + i by default). The lines below FIRST_LINE belong to private per-core sources and are driven low here.

Top module: `cirq_distributor`

## Requirements
- R1: After reset every common interrupt is masked, the unit is disabled, all core lines are low, each mode word reads 0 and each destination mask reads 1 (core 0).
- R2: No interrupt is delivered while the global enable is 0. Opcode 1 sets the enable from data bit 0, and the index is ignored. Clearing the enable stops new deliveries.
- R3: Opcode 2 writes the destination mask of interrupt idx from data bits [NUM_CORE-1:0], one bit per core. Opcode 3 reads it back zero-extended.
- R4: Opcode 4 writes the mode word and opcode 5 reads it back. The mode word has the distribution field in bits [1:0] and the trigger bit in bit 4. All other bits read as zero.
- R5: With distribution field 0 (values 2 and 3 act the same way), the interrupt goes to the lowest-numbered core set in its destination mask. Only one core line of an interrupt is ever high.
- R6: With distribution field 1 (round-robin), each delivery goes to the first set mask bit at or above a per-interrupt pointer, wrapping around. The pointer then moves one past that core. The pointer is 0 after reset.
- R7: With trigger bit 1 (edge), a 0 to 1 input transition sets a pending bit (status bit 1). The pending bit is delivered on the following cycle and cleared by that delivery. An edge that arrives while the interrupt is in service stays pending and is delivered after the acknowledge.
- R8: With trigger bit 0 (level, active high), an input that is high is delivered, and the core line stays high until acknowledged. If the input is still high after the acknowledge, the interrupt is delivered again on the next cycle.
- R9: Opcode 6 with data bit 0 = 1 masks interrupt idx, and with data bit 0 = 0 unmasks it. A masked interrupt is not delivered and its core line is held low. Status bit 0 reads the mask.
- R10: Opcode 7 clears the in-service flag (status bit 2) of interrupt idx. The core line goes low in the cycle after the command.
- R11: Interrupt i drives bit c*LINES + FIRST_LINE + i of core_irq for core c, where LINES = FIRST_LINE + NUM_IRQ. All other bits stay 0.
- R12: Commands whose idx is NUM_IRQ or above change nothing, and reads with such an index return 0. Opcode 8 reads the status word {in-service, pending, mask} in bits [2:0].
- R13: An interrupt with an all-zero destination mask is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Common interrupt inputs, active high |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | IDX_W | Common interrupt index |
| cmd_data | input | DATA_W | Command data word |
| rd_data | output | DATA_W | Readback register, loaded by read commands |
| core_irq | output | NUM_CORE*LINES | Core-side interrupt lines, LINES per core |

## Verification
On every cycle, assertions check four things. Each interrupt drives at most one core line. A delivery starts only while the unit is enabled and the interrupt is unmasked, and only to a core inside its destination mask. An in-service interrupt holds until it is acknowledged and drops after the acknowledge. Each mode readback has its reserved bits at zero.

Some behaviour needs a sequence of stimulus and can only be shown by the directed scenarios. These cover the round-robin order with wrap-around, lowest-bit selection in fixed mode, an edge kept pending during service, level redelivery after acknowledge, line numbering, and the rejection of out-of-range indices.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_ENABLE   = 4'd1,
      OP_SET_DEST = 4'd2,
      OP_RD_DEST  = 4'd3,
      OP_SET_MODE = 4'd4,
      OP_RD_MODE  = 4'd5,
      OP_SET_MASK = 4'd6,
      OP_ACK      = 4'd7,
      OP_RD_STAT  = 4'd8
   } cirq_op_e;

   // mode word layout
   localparam int DISTR_LSB = 0;
   localparam int TRIG_BIT  = 4;

   localparam logic [1:0] DISTR_FIXED = 2'd0;
   localparam logic [1:0] DISTR_RR    = 2'd1;
   localparam logic       TRIG_LEVEL  = 1'b0;
   localparam logic       TRIG_EDGE   = 1'b1;

   // per-interrupt decoded command strobes
   typedef struct packed {
      logic wr_dest;
      logic wr_mode;
      logic wr_mask;
      logic ack;
   } line_cmd_t;

endpackage

// File: rtl/cirq_core_pick.sv
module cirq_core_pick #(
   parameter int NUM_CORE = 4,
   localparam int CIDX_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
   input  logic [NUM_CORE-1:0] dest,
   input  logic [CIDX_W-1:0]   start,
   output logic                found,
   output logic [CIDX_W-1:0]   pick
);

   // circular search for the first set bit at or above start
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < NUM_CORE; k++) begin
         int               cand;
         logic [CIDX_W-1:0] cand_i;
         cand = int'(start) + k;
         if (cand >= NUM_CORE) cand = cand - NUM_CORE;
         cand_i = CIDX_W'(cand);
         if (!found && dest[cand_i]) begin
            found = 1'b1;
            pick  = cand_i;
         end
      end
   end

endmodule

// File: rtl/cirq_line.sv
module cirq_line
   import cirq_pkg::*;
#(
   parameter int NUM_CORE = 4,
   parameter int DATA_W   = 32,
   localparam int CIDX_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                glb_en,
   input  logic                irq_in,
   input  line_cmd_t           cmd,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_CORE-1:0] dest_o,
   output logic [1:0]          distr_o,
   output logic                trig_o,
   output logic                mask_o,
   output logic                pend_o,
   output logic                insvc_o,
   output logic [NUM_CORE-1:0] core_out
);

   logic [NUM_CORE-1:0] dest_q;
   logic [1:0]          distr_q;
   logic                trig_q;
   logic                mask_q;
   logic                pend_q;
   logic                insvc_q;
   logic                prev_q;
   logic [CIDX_W-1:0]   tgt_q;
   logic [CIDX_W-1:0]   rr_ptr_q;

   logic                req;
   logic                rr_mode;
   logic [CIDX_W-1:0]   start;
   logic                found;
   logic [CIDX_W-1:0]   pick;
   logic                deliver;
   logic [CIDX_W-1:0]   next_ptr;
   logic                rise;

   assign rr_mode  = (distr_q == DISTR_RR);
   assign start    = rr_mode ? rr_ptr_q : '0;
   assign req      = (trig_q == TRIG_EDGE) ? pend_q : irq_in;
   assign rise     = irq_in & ~prev_q;
   assign deliver  = glb_en & ~mask_q & req & ~insvc_q & found;
   assign next_ptr = (pick == CIDX_W'(NUM_CORE - 1)) ? '0 : pick + 1'b1;

   cirq_core_pick #(.NUM_CORE(NUM_CORE)) u_pick (
      .dest  (dest_q),
      .start (start),
      .found (found),
      .pick  (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_q   <= NUM_CORE'(1);
         distr_q  <= DISTR_FIXED;
         trig_q   <= TRIG_LEVEL;
         mask_q   <= 1'b1;
         pend_q   <= 1'b0;
         insvc_q  <= 1'b0;
         prev_q   <= 1'b0;
         tgt_q    <= '0;
         rr_ptr_q <= '0;
      end else begin
         prev_q <= irq_in;
         if (cmd.wr_dest) dest_q <= wr_data[NUM_CORE-1:0];
         if (cmd.wr_mode) begin
            distr_q <= wr_data[DISTR_LSB +: 2];
            trig_q  <= wr_data[TRIG_BIT];
         end
         if (cmd.wr_mask) mask_q <= wr_data[0];

         if (trig_q == TRIG_LEVEL)  pend_q <= 1'b0;
         else if (rise)             pend_q <= 1'b1;
         else if (deliver)          pend_q <= 1'b0;

         if (cmd.ack) begin
            insvc_q <= 1'b0;
         end else if (deliver) begin
            insvc_q <= 1'b1;
            tgt_q   <= pick;
            if (rr_mode) rr_ptr_q <= next_ptr;
         end
      end
   end

   // one-hot fan-out towards the cores
   for (genvar c = 0; c < NUM_CORE; c++) begin : g_out
      assign core_out[c] = insvc_q & ~mask_q & (tgt_q == CIDX_W'(c));
   end

   assign dest_o  = dest_q;
   assign distr_o = distr_q;
   assign trig_o  = trig_q;
   assign mask_o  = mask_q;
   assign pend_o  = pend_q;
   assign insvc_o = insvc_q;

   // R5: an interrupt never asserts more than one core line
   p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_out));

   // R2 / R9: service starts only while enabled and unmasked
   p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(insvc_q) |-> ($past(glb_en) && !$past(mask_q)));

   // R13: the chosen core lies inside the destination mask
   p_target_in_dest_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(insvc_q) |-> (|($past(dest_q) & (NUM_CORE'(1) << tgt_q))));

   // R8: service holds until acknowledged
   p_held_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insvc_q && !cmd.ack) |=> insvc_q);

   // R10: acknowledge ends service
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ack |=> !insvc_q);

endmodule

// File: rtl/cirq_distributor.sv
module cirq_distributor
   import cirq_pkg::*;
#(
   parameter int NUM_IRQ    = 4,
   parameter int NUM_CORE   = 4,
   parameter int FIRST_LINE = 24,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 8,
   localparam int LINES     = FIRST_LINE + NUM_IRQ
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        irq_in,
   input  logic                      cmd_valid,
   input  logic [3:0]                cmd_op,
   input  logic [IDX_W-1:0]          cmd_idx,
   input  logic [DATA_W-1:0]         cmd_data,
   output logic [DATA_W-1:0]         rd_data,
   output logic [NUM_CORE*LINES-1:0] core_irq
);

   // elaboration-time parameter checks
   if (NUM_CORE < 2 || NUM_CORE > DATA_W) begin : g_bad_cores
      $error("cirq_distributor: NUM_CORE must lie in 2..DATA_W");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > (1 << IDX_W)) begin : g_bad_irqs
      $error("cirq_distributor: NUM_IRQ must fit the index width");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("cirq_distributor: DATA_W must hold the mode word");
   end

   cirq_op_e op;
   logic     idx_ok;
   logic     glb_en_q;
   logic     is_read;

   assign op      = cirq_op_e'(cmd_op);
   assign idx_ok  = (int'(cmd_idx) < NUM_IRQ);
   assign is_read = (op == OP_RD_DEST) || (op == OP_RD_MODE) || (op == OP_RD_STAT);

   logic [NUM_CORE-1:0] dest_a  [NUM_IRQ];
   logic [1:0]          distr_a [NUM_IRQ];
   logic                trig_a  [NUM_IRQ];
   logic                mask_a  [NUM_IRQ];
   logic                pend_a  [NUM_IRQ];
   logic                insvc_a [NUM_IRQ];
   logic [NUM_CORE-1:0] out_a   [NUM_IRQ];

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      line_cmd_t lc;
      logic      hit;
      assign hit        = cmd_valid && idx_ok && (cmd_idx == IDX_W'(i));
      assign lc.wr_dest = hit && (op == OP_SET_DEST);
      assign lc.wr_mode = hit && (op == OP_SET_MODE);
      assign lc.wr_mask = hit && (op == OP_SET_MASK);
      assign lc.ack     = hit && (op == OP_ACK);

      cirq_line #(.NUM_CORE(NUM_CORE), .DATA_W(DATA_W)) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .glb_en   (glb_en_q),
         .irq_in   (irq_in[i]),
         .cmd      (lc),
         .wr_data  (cmd_data),
         .dest_o   (dest_a[i]),
         .distr_o  (distr_a[i]),
         .trig_o   (trig_a[i]),
         .mask_o   (mask_a[i]),
         .pend_o   (pend_a[i]),
         .insvc_o  (insvc_a[i]),
         .core_out (out_a[i])
      );
   end

   // global enable
   always_ff @(posedge clk) begin
      if (!rst_n)                            glb_en_q <= 1'b0;
      else if (cmd_valid && op == OP_ENABLE) glb_en_q <= cmd_data[0];
   end

   // readback selection
   logic [DATA_W-1:0] rb_val;
   always_comb begin
      rb_val = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (idx_ok && cmd_idx == IDX_W'(i)) begin
            unique case (op)
               OP_RD_DEST: rb_val[NUM_CORE-1:0] = dest_a[i];
               OP_RD_MODE: begin
                  rb_val[DISTR_LSB +: 2] = distr_a[i];
                  rb_val[TRIG_BIT]       = trig_a[i];
               end
               OP_RD_STAT: rb_val[2:0] = {insvc_a[i], pend_a[i], mask_a[i]};
               default:    rb_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     rd_data <= '0;
      else if (cmd_valid && is_read)  rd_data <= rb_val;
   end

   // core-side line map: interrupt i sits at FIRST_LINE + i on each core
   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar l = 0; l < LINES; l++) begin : g_ln
         if (l >= FIRST_LINE) begin : g_common
            assign core_irq[c*LINES + l] = out_a[l - FIRST_LINE][c];
         end else begin : g_private
            assign core_irq[c*LINES + l] = 1'b0;
         end
      end
   end

   // R4: reserved mode-word bits always read as zero
   p_mode_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_valid) && $past(cmd_op) == 4'(OP_RD_MODE))
         |-> (rd_data[3:2] == 2'b00 && (rd_data >> 5) == '0));

endmodule

// File: tb/cirq_distributor_tb_top.sv
module cirq_distributor_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NI    = 4;
   localparam int NC    = 4;
   localparam int FL    = 24;
   localparam int DW    = 32;
   localparam int IW    = 8;
   localparam int LINES = FL + NI;

   localparam logic [3:0] C_EN = 4'd1, C_SDEST = 4'd2, C_RDEST = 4'd3,
                          C_SMODE = 4'd4, C_RMODE = 4'd5, C_SMASK = 4'd6,
                          C_ACK = 4'd7, C_RSTAT = 4'd8;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NI-1:0]          irq_in = '0;
   logic                   cmd_valid = 1'b0;
   logic [3:0]             cmd_op = '0;
   logic [IW-1:0]          cmd_idx = '0;
   logic [DW-1:0]          cmd_data = '0;
   logic [DW-1:0]          rd_data;
   logic [NC*LINES-1:0]    core_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cirq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC), .FIRST_LINE(FL),
                      .DATA_W(DW), .IDX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
      .rd_data(rd_data), .core_irq(core_irq));

   task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_cmd(logic [3:0] op, int idx, logic [DW-1:0] data);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0; cmd_data = '0;
   endtask

   task automatic rd(logic [3:0] op, int idx, output logic [DW-1:0] v);
      do_cmd(op, idx, '0);
      v = rd_data;
   endtask

   function automatic logic [NC-1:0] cores_of(int i);
      logic [NC-1:0] m;
      for (int c = 0; c < NC; c++) m[c] = core_irq[c*LINES + FL + i];
      return m;
   endfunction

   task automatic pulse(int i);
      @(negedge clk); irq_in[i] = 1'b1;
      @(negedge clk); irq_in[i] = 1'b0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R1 lines low", core_irq, '0);
      rd(C_RMODE, 0, v); chk("R1 mode reset", v, 0);
      rd(C_RDEST, 2, v); chk("R1 dest reset", v, 1);
      rd(C_RSTAT, 3, v); chk("R1 masked at reset", v, 1);
   endtask

   task automatic t_enable();
      logic [NC*LINES-1:0] exp;
      do_cmd(C_SDEST, 0, 32'h2);
      do_cmd(C_SMODE, 0, 32'h0);
      do_cmd(C_SMASK, 0, 32'h0);
      irq_in[0] = 1'b1;
      idle(3);
      chk("R2 nothing before enable", core_irq, '0);
      do_cmd(C_EN, 3, 32'h1);
      idle(2);
      exp = '0; exp[1*LINES + FL + 0] = 1'b1;
      chk("R11 line 24 on core 1", core_irq, exp);
      irq_in[0] = 1'b0;
      do_cmd(C_ACK, 0, 0);
      chk("R10 line low after ack", core_irq, '0);
      do_cmd(C_SMASK, 0, 32'h1);
   endtask

   task automatic t_mode_dest();
      logic [DW-1:0] v;
      do_cmd(C_SMODE, 3, 32'hFFFF_FFFF);
      rd(C_RMODE, 3, v); chk("R4 mode fields only", v, 32'h13);
      do_cmd(C_SMODE, 3, 32'h0);
      rd(C_RMODE, 3, v); chk("R4 mode cleared", v, 0);
      do_cmd(C_SDEST, 3, 32'hFFFF_FFF5);
      rd(C_RDEST, 3, v); chk("R3 dest readback", v, 32'h5);
   endtask

   task automatic t_round_robin();
      logic [NC-1:0] seq [5] = '{4'b0001, 4'b0010, 4'b1000, 4'b0001, 4'b0010};
      do_cmd(C_SMODE, 1, 32'h11);
      do_cmd(C_SDEST, 1, 32'hB);
      do_cmd(C_SMASK, 1, 32'h0);
      for (int n = 0; n < 5; n++) begin
         pulse(1);
         idle(3);
         chk($sformatf("R6 rr delivery %0d", n), cores_of(1), seq[n]);
         do_cmd(C_ACK, 1, 0);
         idle(1);
      end
      do_cmd(C_SMASK, 1, 32'h1);
   endtask

   task automatic t_fixed();
      do_cmd(C_SMODE, 1, 32'h0);
      do_cmd(C_SDEST, 1, 32'hA);
      do_cmd(C_SMASK, 1, 32'h0);
      irq_in[1] = 1'b1;
      idle(3);
      chk("R5 fixed lowest bit", cores_of(1), 4'b0010);
      irq_in[1] = 1'b0;
      do_cmd(C_ACK, 1, 0);
      do_cmd(C_SMODE, 1, 32'h2);
      do_cmd(C_SDEST, 1, 32'hC);
      irq_in[1] = 1'b1;
      idle(3);
      chk("R5 mode 2 acts fixed", cores_of(1), 4'b0100);
      irq_in[1] = 1'b0;
      do_cmd(C_ACK, 1, 0);
      do_cmd(C_SMASK, 1, 32'h1);
   endtask

   task automatic t_edge();
      logic [DW-1:0] v;
      do_cmd(C_SMODE, 2, 32'h10);
      do_cmd(C_SDEST, 2, 32'h1);
      do_cmd(C_SMASK, 2, 32'h0);
      pulse(2);
      idle(3);
      chk("R7 edge delivered", cores_of(2), 4'b0001);
      pulse(2);
      idle(2);
      rd(C_RSTAT, 2, v); chk("R7 pending kept in service", v, 32'h6);
      do_cmd(C_ACK, 2, 0);
      idle(1);
      chk("R7 pending redelivered", cores_of(2), 4'b0001);
      do_cmd(C_ACK, 2, 0);
      idle(2);
      rd(C_RSTAT, 2, v); chk("R7 idle after second ack", v, 32'h0);
      do_cmd(C_SMASK, 2, 32'h1);
   endtask

   task automatic t_level();
      do_cmd(C_SMODE, 3, 32'h0);
      do_cmd(C_SDEST, 3, 32'h8);
      do_cmd(C_SMASK, 3, 32'h0);
      irq_in[3] = 1'b1;
      idle(3);
      chk("R8 level delivered", cores_of(3), 4'b1000);
      idle(5);
      chk("R8 held until ack", cores_of(3), 4'b1000);
      do_cmd(C_ACK, 3, 0);
      chk("R10 low right after ack", cores_of(3), 4'b0000);
      idle(1);
      chk("R8 redelivered while high", cores_of(3), 4'b1000);
      irq_in[3] = 1'b0;
      do_cmd(C_ACK, 3, 0);
      idle(2);
      chk("R8 quiet after input low", cores_of(3), 4'b0000);
      do_cmd(C_SMASK, 3, 32'h1);
   endtask

   task automatic t_mask();
      logic [DW-1:0] v;
      do_cmd(C_SDEST, 0, 32'h1);
      irq_in[0] = 1'b1;
      idle(3);
      chk("R9 masked no delivery", cores_of(0), 4'b0000);
      do_cmd(C_SMASK, 0, 32'h0);
      idle(2);
      chk("R9 unmask delivers", cores_of(0), 4'b0001);
      do_cmd(C_SMASK, 0, 32'h1);
      chk("R9 mask gates line", cores_of(0), 4'b0000);
      rd(C_RSTAT, 0, v); chk("R9 status masked in service", v, 32'h5);
      irq_in[0] = 1'b0;
      do_cmd(C_ACK, 0, 0);
   endtask

   task automatic t_out_of_range();
      logic [DW-1:0] v;
      do_cmd(C_SMODE, NI, 32'h11);
      rd(C_RMODE, 0, v); chk("R12 no alias to irq 0", v, 0);
      rd(C_RMODE, NI, v); chk("R12 out of range reads 0", v, 0);
      do_cmd(C_SMASK, NI, 32'h0);
      rd(C_RSTAT, 0, v); chk("R12 mask untouched", v, 32'h1);
   endtask

   task automatic t_empty_dest();
      logic [DW-1:0] v;
      do_cmd(C_SDEST, 3, 32'h0);
      do_cmd(C_SMASK, 3, 32'h0);
      irq_in[3] = 1'b1;
      idle(3);
      chk("R13 empty dest no line", core_irq, '0);
      rd(C_RSTAT, 3, v); chk("R13 not in service", v, 32'h0);
      irq_in[3] = 1'b0;
      do_cmd(C_SMASK, 3, 32'h1);
   endtask

   task automatic t_disable();
      logic [DW-1:0] v;
      do_cmd(C_EN, 0, 32'h0);
      do_cmd(C_SDEST, 0, 32'h1);
      do_cmd(C_SMASK, 0, 32'h0);
      irq_in[0] = 1'b1;
      idle(3);
      chk("R2 disabled no delivery", core_irq, '0);
      rd(C_RSTAT, 0, v); chk("R2 disabled not in service", v, 32'h0);
      irq_in[0] = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_enable();
      t_mode_dest();
      t_round_robin();
      t_fixed();
      t_edge();
      t_level();
      t_mask();
      t_out_of_range();
      t_empty_dest();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule